// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog with five 16-bit registers on a simple write-strobe bus with combinational read-back. It counts down in half-second steps. The steps come from a prescaler that divides a 32.768 kHz enable strobe. Software programs a timeout field, and once the watchdog is enabled it cannot be turned off again until reset. The only way to restart the countdown is to write two key words to the service register in a fixed order. When the count runs out, the block raises either an internal chip-reset request or an active-low external reset, depending on a control bit. That output stays asserted until the warm reset arrives.

A maskable early-warning interrupt fires a programmable number of half-seconds before expiry. A status bit, which survives warm reset, records whether the last warm reset followed a timeout. A set-once control bit freezes counting while a low-power input is high. Two active-low control bits let software request an internal or an external reset directly.

Two resets are used. `por_n` clears everything. `rst_n` is the warm reset, which the chip asserts in answer to the reset request. It clears everything except the reset-cause record.

Top module: `wdog_core`

## Requirements
- R1: After reset, the control register (offset 0x0) reads 0x0030, the misc register (offset 0x8) reads 0x0001, the status (offset 0x4) and interrupt control (offset 0x6) registers read 0, `chip_rst_req_o` and `irq_o` are low, and `ext_rst_n_o` is high.
- R2: Control bits [15:8] hold the timeout field F. A load happens when enable bit 2 goes from 0 to 1, taking F from the same write. Exactly (F+1)·DIV strobes of `tick32k_i` after the load edge, the timeout action fires.
- R3: Writing 0x5555 and then 0xAAAA to the service register (offset 0x2) reloads the countdown from the current F. A change to F takes effect only at the next load.
- R4: A lone 0xAAAA does not reload the countdown. Neither does 0xAAAA written after 0x5555 when another value was written in between.
- R5: Once control bit 2 (enable) is set, writing 0 to it leaves it at 1, and the countdown continues.
- R6: Control bit 0 can be set but not cleared. While it is 1 and `lowpwr_i` is high, the countdown holds; counting resumes when `lowpwr_i` drops.
- R7: Control bit 3 selects the timeout action. With 0, a timeout raises `chip_rst_req_o`. With 1, a timeout drives only `ext_rst_n_o` low. The action output stays asserted until `rst_n` is applied.
- R8: Writing 0 to control bit 4 raises `chip_rst_req_o` until reset. Control bit 5 drives `ext_rst_n_o` directly: 0 asserts it and 1 releases it.
- R9: Status bit 1 reads 1 after a warm reset that ended a timeout. It reads 0 after a warm reset that did not, and 0 after `por_n`.
- R10: In the interrupt control register, bit 15 enables the interrupt and bits [7:0] give the lead L in half-seconds. Bit 14 sets when the remaining count steps down to L (with L not 0), and writing 1 to bit 14 clears it. `irq_o` equals bit 14 AND bit 15.
- R11: Misc bit 0 reads 1 after reset. Writing 0 clears it, and a later write of 1 does not set it again.
- R12: While control bit 2 is 0, no countdown runs and no timeout action occurs, even after a service sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Warm reset, active low, keeps the reset-cause bit |
| tick32k_i | input | 1 | 32.768 kHz enable strobe, one clock wide |
| lowpwr_i | input | 1 | Low-power mode indication |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| chip_rst_req_o | output | 1 | Internal chip reset request, active high |
| ext_rst_n_o | output | 1 | External reset output, active low |
| irq_o | output | 1 | Pre-timeout interrupt |

## Verification
The bench samples expiry on exactly the edge where it is due, and also one edge earlier. A design that loads F instead of F+1, or that counts the load edge as a step, is caught by this off-by-one window. Broken key orders (a lone second key, or an intruding word between the keys) are timed so that a design that wrongly reloads would fire four cycles late. A timeout-field rewrite without a reload is timed so that applying it at once shows up as a wrong expiry edge. The bench also checks the reset-cause bit across two warm resets in a row, and across a software-requested reset. A design that clears the bit on the wrong reset, or keeps it stale, reports the wrong cause.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SVC  = 4'h2;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_ICR  = 4'h6;
    localparam logic [3:0] OFS_MISC = 4'h8;

    localparam logic [15:0] KEY_FIRST  = 16'h5555;
    localparam logic [15:0] KEY_SECOND = 16'hAAAA;

    typedef struct packed {
        logic [7:0] tmo;
        logic       ext_n;
        logic       sw_n;
        logic       act_ext;
        logic       run;
        logic       lp_freeze;
    } ctrl_t;

    typedef struct packed {
        ctrl_t      ctrl;
        logic       irq_en;
        logic       irq_flag;
        logic [7:0] lead;
        logic       pdn_en;
    } regs_t;

    typedef struct packed {
        logic fire_int;
        logic fire_ext;
        logic cause;
        logic in_rst;
    } keep_t;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int unsigned DIV = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic run_i,
    input  logic clr_i,
    output logic half_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        half_o = 1'b0;
        if (clr_i) begin
            cnt_d = '0;
        end else if (run_i && strobe_i) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                half_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] data_i,
    output logic        reload_o
);
    logic armed_d, armed_q;

    always_comb begin
        armed_d  = armed_q;
        reload_o = 1'b0;
        if (wr_i) begin
            if (data_i == KEY_FIRST) begin
                armed_d = 1'b1;
            end else if (data_i == KEY_SECOND && armed_q) begin
                reload_o = 1'b1;
                armed_d  = 1'b0;
            end else begin
                armed_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= armed_d;
    end
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int unsigned CW = 9,
    parameter int unsigned LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          step_i,
    input  logic [LW-1:0] lead_i,
    output logic [CW-1:0] cnt_o,
    output logic          expire_o,
    output logic          lead_hit_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] dec;

    assign dec   = cnt_q - 1'b1;
    assign cnt_o = cnt_q;

    always_comb begin
        cnt_d      = cnt_q;
        expire_o   = 1'b0;
        lead_hit_o = 1'b0;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (step_i && cnt_q != '0) begin
            cnt_d      = dec;
            expire_o   = (dec == '0);
            lead_hit_o = (lead_i != '0) && (dec == CW'(lead_i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int unsigned DIV = 16384
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_n,
    input  logic        tick32k_i,
    input  logic        lowpwr_i,
    input  logic        wr_en_i,
    input  logic [3:0]  addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        chip_rst_req_o,
    output logic        ext_rst_n_o,
    output logic        irq_o
);
    localparam int unsigned TW = 8;
    localparam int unsigned CW = TW + 1;

    regs_t st_d, st_q;
    keep_t kp_d, kp_q;

    logic          wr_ctrl, wr_svc, wr_icr, wr_misc;
    logic          svc_reload, run_rise, load;
    logic [TW-1:0] load_tmo;
    logic [CW-1:0] load_val, cnt;
    logic          half_tick, expire, lead_hit, pres_run;

    // signals observed by the bound checker
    logic wde_w, lpf_w, fire_any_w, fire_ext_w, pst_w;

    assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
    assign wr_svc  = wr_en_i && (addr_i == OFS_SVC);
    assign wr_icr  = wr_en_i && (addr_i == OFS_ICR);
    assign wr_misc = wr_en_i && (addr_i == OFS_MISC);

    assign run_rise = wr_ctrl && wdata_i[2] && !st_q.ctrl.run;
    assign load     = run_rise || svc_reload;
    assign load_tmo = wr_ctrl ? wdata_i[15:8] : st_q.ctrl.tmo;
    assign load_val = {1'b0, load_tmo} + 1'b1;
    assign pres_run = st_q.ctrl.run && !(st_q.ctrl.lp_freeze && lowpwr_i) && (cnt != '0);

    wdog_keyseq u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_svc),
        .data_i   (wdata_i),
        .reload_o (svc_reload)
    );

    wdog_prescale #(.DIV(DIV)) u_pres (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (tick32k_i),
        .run_i    (pres_run),
        .clr_i    (load),
        .half_o   (half_tick)
    );

    wdog_countdown #(.CW(CW), .LW(TW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (load_val),
        .step_i     (half_tick),
        .lead_i     (st_q.lead),
        .cnt_o      (cnt),
        .expire_o   (expire),
        .lead_hit_o (lead_hit)
    );

    // register file next state
    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.tmo       = wdata_i[15:8];
            st_d.ctrl.ext_n     = wdata_i[5];
            st_d.ctrl.sw_n      = st_q.ctrl.sw_n & wdata_i[4];
            st_d.ctrl.act_ext   = wdata_i[3];
            st_d.ctrl.run       = st_q.ctrl.run | wdata_i[2];
            st_d.ctrl.lp_freeze = st_q.ctrl.lp_freeze | wdata_i[0];
        end
        if (wr_icr) begin
            st_d.irq_en = wdata_i[15];
            st_d.lead   = wdata_i[7:0];
            if (wdata_i[14]) st_d.irq_flag = 1'b0;
        end
        if (lead_hit) st_d.irq_flag = 1'b1;
        if (wr_misc) st_d.pdn_en = st_q.pdn_en & wdata_i[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                <= '0;
            st_q.ctrl.ext_n     <= 1'b1;
            st_q.ctrl.sw_n      <= 1'b1;
            st_q.pdn_en         <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // timeout record, kept across warm reset
    always_comb begin
        kp_d = kp_q;
        if (!rst_n) begin
            if (!kp_q.in_rst) kp_d.cause = kp_q.fire_int | kp_q.fire_ext;
            kp_d.fire_int = 1'b0;
            kp_d.fire_ext = 1'b0;
            kp_d.in_rst   = 1'b1;
        end else begin
            kp_d.in_rst   = 1'b0;
            kp_d.fire_int = kp_q.fire_int | (expire & ~st_q.ctrl.act_ext);
            kp_d.fire_ext = kp_q.fire_ext | (expire &  st_q.ctrl.act_ext);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) kp_q <= '0;
        else        kp_q <= kp_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFS_CTRL: rdata_o = {st_q.ctrl.tmo, 2'b00, st_q.ctrl.ext_n, st_q.ctrl.sw_n,
                                 st_q.ctrl.act_ext, st_q.ctrl.run, 1'b0, st_q.ctrl.lp_freeze};
            OFS_STAT: rdata_o = {14'd0, kp_q.cause, 1'b0};
            OFS_ICR:  rdata_o = {st_q.irq_en, st_q.irq_flag, 6'd0, st_q.lead};
            OFS_MISC: rdata_o = {15'd0, st_q.pdn_en};
            default:  rdata_o = '0;
        endcase
    end

    assign chip_rst_req_o = kp_q.fire_int | ~st_q.ctrl.sw_n;
    assign ext_rst_n_o    = ~kp_q.fire_ext & st_q.ctrl.ext_n;
    assign irq_o          = st_q.irq_flag & st_q.irq_en;

    assign wde_w      = st_q.ctrl.run;
    assign lpf_w      = st_q.ctrl.lp_freeze;
    assign fire_any_w = kp_q.fire_int | kp_q.fire_ext;
    assign fire_ext_w = kp_q.fire_ext;
    assign pst_w      = st_q.irq_flag;
endmodule

// File: rtl/wdog_core_chk.sv
module wdog_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_rst_req_o,
    input logic       lowpwr_i,
    input logic       wde,
    input logic       lpf,
    input logic       fire_any,
    input logic       fire_ext,
    input logic       pst,
    input logic       load,
    input logic       half_tick,
    input logic [8:0] cnt
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req_o |=> chip_rst_req_o); // R7
    AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire_ext |=> fire_ext); // R7
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wde |=> wde); // R5
    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lpf && lowpwr_i && !load) |=> $stable(cnt)); // R6
    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !wde |-> !half_tick); // R12
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fire_any) |-> (cnt == 9'd0)); // R2
    AST_PRE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pst) |-> $past(half_tick)); // R10
endmodule

bind wdog_core wdog_core_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .chip_rst_req_o (chip_rst_req_o),
    .lowpwr_i       (lowpwr_i),
    .wde            (wde_w),
    .lpf            (lpf_w),
    .fire_any       (fire_any_w),
    .fire_ext       (fire_ext_w),
    .pst            (pst_w),
    .load           (load),
    .half_tick      (half_tick),
    .cnt            (cnt)
);

// File: tb/wdog_core_bench.sv
module wdog_core_bench;
    localparam int unsigned DIV = 4;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic        tick32k_i = 1'b1, lowpwr_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  addr_i = 4'h0;
    logic [15:0] wdata_i = 16'h0;
    logic [15:0] rdata_o;
    logic        chip_rst_req_o, ext_rst_n_o, irq_o;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    wdog_core #(.DIV(DIV)) u_wdog_core (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick32k_i(tick32k_i),
        .lowpwr_i(lowpwr_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .chip_rst_req_o(chip_rst_req_o),
        .ext_rst_n_o(ext_rst_n_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic warm_reset();
        rst_n = 1'b0; cyc(3); rst_n = 1'b1; cyc(1);
    endtask

    task automatic full_reset();
        por_n = 1'b0; rst_n = 1'b0; lowpwr_i = 1'b0; cyc(3);
        por_n = 1'b1; rst_n = 1'b1; cyc(1);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        full_reset();
        rd(4'h0, d); chk("R1 ctrl", d, 16'h0030);
        rd(4'h8, d); chk("R1 misc", d, 16'h0001);
        rd(4'h4, d); chk("R1 status", d, 16'h0000);
        rd(4'h6, d); chk("R1 icr", d, 16'h0000);
        chk("R1 outputs", {13'd0, chip_rst_req_o, ext_rst_n_o, irq_o}, 16'h0002);
    endtask

    task automatic t_disabled();
        full_reset();
        wr(4'h0, 16'h0030);
        wr(4'h2, 16'h5555); wr(4'h2, 16'hAAAA);
        cyc(40);
        chk("R12 no action", {14'd0, chip_rst_req_o, ext_rst_n_o}, 16'h0001);
    endtask

    task automatic t_timeout();
        logic [15:0] d;
        full_reset();
        wr(4'h0, 16'h0234);              // F=2: 12 cycles
        cyc(11); chk("R2 early", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1);  chk("R2 fire", {15'd0, chip_rst_req_o}, 16'h1);
        chk("R7 ext idle", {15'd0, ext_rst_n_o}, 16'h1);
        cyc(5);  chk("R7 held", {15'd0, chip_rst_req_o}, 16'h1);
        warm_reset();
        chk("R7 released", {15'd0, chip_rst_req_o}, 16'h0);
        rd(4'h4, d); chk("R9 cause set", d, 16'h0002);
        rd(4'h0, d); chk("R9 ctrl cleared", d, 16'h0030);
        warm_reset();
        rd(4'h4, d); chk("R9 cause cleared", d, 16'h0000);
    endtask

    task automatic t_por_cause();
        logic [15:0] d;
        full_reset();
        wr(4'h0, 16'h0034);
        cyc(6);
        warm_reset();
        rd(4'h4, d); chk("R9 pre-por", d, 16'h0002);
        full_reset();
        rd(4'h4, d); chk("R9 after por", d, 16'h0000);
    endtask

    task automatic t_field_change();
        full_reset();
        wr(4'h0, 16'h0134);              // F=1: fire 8 edges after load
        wr(4'h0, 16'h0734);
        cyc(6); chk("R3 no early apply", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1); chk("R3 old field", {15'd0, chip_rst_req_o}, 16'h1);
    endtask

    task automatic t_service();
        full_reset();
        wr(4'h0, 16'h0334);              // F=3
        cyc(7);
        wr(4'h0, 16'h0134);              // new F=1
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'hAAAA);              // reload edge
        cyc(7); chk("R3 reload early", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1); chk("R3 reload fire", {15'd0, chip_rst_req_o}, 16'h1);
    endtask

    task automatic t_badseq();
        full_reset();
        wr(4'h0, 16'h0334);              // F=3: fire at load+16
        wr(4'h2, 16'hAAAA);
        wr(4'h2, 16'h5555);
        wr(4'h2, 16'h1234);
        wr(4'h2, 16'hAAAA);
        cyc(11); chk("R4 early", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1);  chk("R4 no reload", {15'd0, chip_rst_req_o}, 16'h1);
    endtask

    task automatic t_sticky();
        logic [15:0] d;
        full_reset();
        wr(4'h0, 16'h0134);
        wr(4'h0, 16'h0130);
        rd(4'h0, d); chk("R5 readback", d, 16'h0134);
        cyc(6); chk("R5 early", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1); chk("R5 still runs", {15'd0, chip_rst_req_o}, 16'h1);
    endtask

    task automatic t_freeze();
        logic [15:0] d;
        full_reset();
        lowpwr_i = 1'b1;
        wr(4'h0, 16'h0135);
        cyc(40);
        chk("R6 frozen", {15'd0, chip_rst_req_o}, 16'h0);
        wr(4'h0, 16'h0134);
        rd(4'h0, d); chk("R6 set once", d, 16'h0135);
        lowpwr_i = 1'b0;
        cyc(7); chk("R6 resume early", {15'd0, chip_rst_req_o}, 16'h0);
        cyc(1); chk("R6 resume fire", {15'd0, chip_rst_req_o}, 16'h1);
    endtask

    task automatic t_ext();
        logic [15:0] d;
        full_reset();
        wr(4'h0, 16'h013C);
        cyc(7); chk("R7 ext early", {15'd0, ext_rst_n_o}, 16'h1);
        cyc(1); chk("R7 ext fire", {14'd0, chip_rst_req_o, ext_rst_n_o}, 16'h0);
        cyc(4); chk("R7 ext held", {15'd0, ext_rst_n_o}, 16'h0);
        warm_reset();
        chk("R7 ext released", {15'd0, ext_rst_n_o}, 16'h1);
        rd(4'h4, d); chk("R9 ext cause", d, 16'h0002);
    endtask

    task automatic t_swreset();
        logic [15:0] d;
        full_reset();
        wr(4'h0, 16'h0020);
        chk("R8 sw req", {15'd0, chip_rst_req_o}, 16'h1);
        wr(4'h0, 16'h0030);
        chk("R8 sw held", {15'd0, chip_rst_req_o}, 16'h1);
        warm_reset();
        chk("R8 sw cleared", {15'd0, chip_rst_req_o}, 16'h0);
        rd(4'h4, d); chk("R9 not timeout", d, 16'h0000);
        wr(4'h0, 16'h0010);
        chk("R8 ext assert", {15'd0, ext_rst_n_o}, 16'h0);
        wr(4'h0, 16'h0030);
        chk("R8 ext release", {15'd0, ext_rst_n_o}, 16'h1);
    endtask

    task automatic t_pretimeout();
        logic [15:0] d;
        full_reset();
        wr(4'h6, 16'h8002);
        wr(4'h0, 16'h0434);              // F=4, load at this edge
        cyc(11); chk("R10 early", {15'd0, irq_o}, 16'h0);
        cyc(1);  chk("R10 irq", {15'd0, irq_o}, 16'h1);
        rd(4'h6, d); chk("R10 flag", d, 16'hC002);
        wr(4'h6, 16'hC002);
        chk("R10 w1c", {15'd0, irq_o}, 16'h0);
        rd(4'h6, d); chk("R10 flag clear", d, 16'h8002);
    endtask

    task automatic t_misc();
        logic [15:0] d;
        full_reset();
        wr(4'h8, 16'h0000);
        rd(4'h8, d); chk("R11 cleared", d, 16'h0000);
        wr(4'h8, 16'h0001);
        rd(4'h8, d); chk("R11 stays", d, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_disabled();
        t_timeout();
        t_por_cause();
        t_field_change();
        t_service();
        t_badseq();
        t_sticky();
        t_freeze();
        t_ext();
        t_swreset();
        t_pretimeout();
        t_misc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule